// File: doc/BRIEF.md
# Operand-Managing Function Unit Controller

This block is the control and latch logic that sits in front of one execution pipeline in a scoreboard-style out-of-order core. It takes an issued operation and fetches that operation's source operands. It refers to each operand only by its index, never by a register number. For each index it raises a read request and then waits for the matching grant, which arrives once the read hazard is gone. The operand data is captured into a local input latch on the grant cycle.

When the last operand has been captured, the block launches the operation into the attached pipeline. If the operation produces a result, the block stays busy until the pipeline returns that result. It then captures the result in an output latch and requests a write port. It reports done only after the write grant. An operation with no result, such as a store, reports done as soon as its operands are handed to the pipeline.

No central sequencer drives the block. Each step is taken when a blocking condition is released. The input and output latches carry no register names. Each added instance of the block therefore adds nameless in-flight storage, and this storage acts as implicit renaming.

Top module: `fu_opnd_ctrl`

## Requirements
- R1: While reset is held and just after it, busy, done, pipeGo, wrReq and issueErr are 0 and rdReq is all zeros.
- R2: An issue pulse seen in the idle state is accepted. In the next cycle busy is 1 and rdReq requests operand 0 (rdReq bit i requests operand i).
- R3: Operand requests go out one at a time in rising index order, and rdReq is never more than one-hot. A request stays asserted until the grant bit of the same index is seen. A grant on any other index is ignored.
- R4: The rdData value on the cycle of the grant for operand i is held in pipeOperands[i*DATA_W +: DATA_W].
- R5: pipeGo is a one-cycle pulse in the cycle after the grant of the last operand. In that cycle pipeOpcode equals the issued opcode.
- R6: For an operation with a result, done and wrReq stay 0 after the launch until pipeResultValid is seen.
- R7: After the result is captured, wrReq stays 1 and wrData stays equal to the captured result until wrGrant. Later changes on pipeResult have no effect on wrData.
- R8: done is a one-cycle pulse in the cycle after wrGrant. In the cycle after done, busy is 0.
- R9: An operation issued with issueHasResult = 0 raises done in the same cycle as pipeGo. It never raises wrReq.
- R10: An issue that arrives while busy is ignored, and the in-flight operation goes on with its own opcode. Such an issue sets issueErr, which stays 1 until reset.
- R11: While a read grant or a write grant is withheld, the block holds its request and does not advance, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue pulse for a new operation |
| issueOpcode | input | OPC_W | Opcode of the issued operation |
| issueHasResult | input | 1 | 1 if the operation writes a result |
| rdReq | output | NUM_OPS | One-hot operand read request, bit i = operand i |
| rdGrant | input | NUM_OPS | Per-operand read grant |
| rdData | input | DATA_W | Register file read data, valid with the grant |
| pipeGo | output | 1 | One-cycle launch pulse to the pipeline |
| pipeOpcode | output | OPC_W | Latched opcode |
| pipeOperands | output | NUM_OPS*DATA_W | Input latches, operand i at slice i |
| pipeResultValid | input | 1 | Pipeline result strobe |
| pipeResult | input | DATA_W | Pipeline result data |
| wrReq | output | 1 | Write port request |
| wrData | output | DATA_W | Output latch contents |
| wrGrant | input | 1 | Write port grant |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in flight |
| issueErr | output | 1 | Sticky flag: issue arrived while busy |

## Verification
On every cycle the assertions check the following: the read request is one-hot and held until its own grant, the write request and output data are held until the write grant, and done is a single pulse followed by idle. They also check that done without a launch in the same cycle always follows a write grant, and that the error flag is sticky. Only the directed scenarios can show the rest. These are the captured operand values, the exact launch cycle and its opcode, the long waits with grants withheld, and the correct ignoring of wrong-index grants and late issues.

// File: rtl/fu_opnd_pkg.sv
package fu_opnd_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_OPS  = 3'd1,
    ST_EXEC_WAIT = 3'd2,
    ST_WRITE_REQ = 3'd3,
    ST_DONE      = 3'd4
  } ctrlState_e;

  typedef struct packed {
    logic             loadIssue;
    logic             capOperand;
    logic [SEL_W-1:0] opSel;
    logic             capResult;
  } dpStrobe_t;

endpackage

// File: rtl/fu_opnd_ctrl_fsm.sv
module fu_opnd_ctrl_fsm
  import fu_opnd_pkg::*;
#(
  parameter int NUM_OPS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               issueHasResult,
  input  logic [NUM_OPS-1:0] rdGrant,
  input  logic               pipeResultValid,
  input  logic               wrGrant,
  output logic [NUM_OPS-1:0] rdReq,
  output logic               pipeGo,
  output logic               wrReq,
  output logic               done,
  output logic               busy,
  output logic               issueErr,
  output dpStrobe_t          strobe
);

  localparam int IDX_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OPS - 1);

  ctrlState_e stateQ, stateD;
  logic [IDX_W-1:0] opIdxQ, opIdxD;
  logic hasResQ, hasResD;
  logic goQ, goD;
  logic errQ;
  logic grantHit, lastOp;

  assign lastOp   = (opIdxQ == LAST_IDX);
  assign grantHit = (stateQ == ST_READ_OPS) && rdGrant[opIdxQ];

  always_comb begin
    stateD  = stateQ;
    opIdxD  = opIdxQ;
    hasResD = hasResQ;
    goD     = 1'b0;
    strobe  = '0;
    strobe.opSel = SEL_W'(opIdxQ);
    unique case (stateQ)
      ST_IDLE: begin
        if (issueValid) begin
          stateD  = ST_READ_OPS;
          opIdxD  = '0;
          hasResD = issueHasResult;
          strobe.loadIssue = 1'b1;
        end
      end
      ST_READ_OPS: begin
        if (grantHit) begin
          strobe.capOperand = 1'b1;
          if (lastOp) begin
            goD    = 1'b1;
            stateD = hasResQ ? ST_EXEC_WAIT : ST_DONE;
          end else begin
            opIdxD = opIdxQ + 1'b1;
          end
        end
      end
      ST_EXEC_WAIT: begin
        if (pipeResultValid) begin
          strobe.capResult = 1'b1;
          stateD = ST_WRITE_REQ;
        end
      end
      ST_WRITE_REQ: begin
        if (wrGrant) stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      opIdxQ  <= '0;
      hasResQ <= 1'b0;
      goQ     <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      stateQ  <= stateD;
      opIdxQ  <= opIdxD;
      hasResQ <= hasResD;
      goQ     <= goD;
      if (issueValid && (stateQ != ST_IDLE)) errQ <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_req
      assign rdReq[i] = (stateQ == ST_READ_OPS) && (opIdxQ == IDX_W'(i));
    end
  endgenerate

  assign pipeGo   = goQ;
  assign wrReq    = (stateQ == ST_WRITE_REQ);
  assign done     = (stateQ == ST_DONE);
  assign busy     = (stateQ != ST_IDLE);
  assign issueErr = errQ;

endmodule

// File: rtl/fu_opnd_latches.sv
module fu_opnd_latches
  import fu_opnd_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int DATA_W  = 32,
  parameter int OPC_W   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [OPC_W-1:0]          issueOpcode,
  input  logic [DATA_W-1:0]         rdData,
  input  logic [DATA_W-1:0]         pipeResult,
  output logic [OPC_W-1:0]          pipeOpcode,
  output logic [NUM_OPS*DATA_W-1:0] pipeOperands,
  output logic [DATA_W-1:0]         wrData
);

  logic [OPC_W-1:0]  opcodeQ;
  logic [DATA_W-1:0] resultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.loadIssue) opcodeQ <= issueOpcode;
      if (strobe.capResult) resultQ <= pipeResult;
    end
  end

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_opnd
      logic [DATA_W-1:0] slotQ;
      always_ff @(posedge clk) begin
        if (!rstN) slotQ <= '0;
        else if (strobe.capOperand && (strobe.opSel == SEL_W'(i))) slotQ <= rdData;
      end
      assign pipeOperands[i*DATA_W +: DATA_W] = slotQ;
    end
  endgenerate

  assign pipeOpcode = opcodeQ;
  assign wrData     = resultQ;

endmodule

// File: rtl/fu_opnd_ctrl.sv
module fu_opnd_ctrl
  import fu_opnd_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int DATA_W  = 32,
  parameter int OPC_W   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      issueValid,
  input  logic [OPC_W-1:0]          issueOpcode,
  input  logic                      issueHasResult,
  output logic [NUM_OPS-1:0]        rdReq,
  input  logic [NUM_OPS-1:0]        rdGrant,
  input  logic [DATA_W-1:0]         rdData,
  output logic                      pipeGo,
  output logic [OPC_W-1:0]          pipeOpcode,
  output logic [NUM_OPS*DATA_W-1:0] pipeOperands,
  input  logic                      pipeResultValid,
  input  logic [DATA_W-1:0]         pipeResult,
  output logic                      wrReq,
  output logic [DATA_W-1:0]         wrData,
  input  logic                      wrGrant,
  output logic                      done,
  output logic                      busy,
  output logic                      issueErr
);

  dpStrobe_t strobe;

  fu_opnd_ctrl_fsm #(.NUM_OPS(NUM_OPS)) u_fsm (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueHasResult(issueHasResult),
    .rdGrant(rdGrant), .pipeResultValid(pipeResultValid), .wrGrant(wrGrant),
    .rdReq(rdReq), .pipeGo(pipeGo), .wrReq(wrReq), .done(done),
    .busy(busy), .issueErr(issueErr), .strobe(strobe)
  );

  fu_opnd_latches #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueOpcode(issueOpcode), .rdData(rdData), .pipeResult(pipeResult),
    .pipeOpcode(pipeOpcode), .pipeOperands(pipeOperands), .wrData(wrData)
  );

endmodule

// File: rtl/fu_opnd_ctrl_chk.sv
module fu_opnd_ctrl_chk #(
  parameter int NUM_OPS = 2,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_OPS-1:0] rdReq,
  input logic [NUM_OPS-1:0] rdGrant,
  input logic               pipeGo,
  input logic               wrReq,
  input logic               wrGrant,
  input logic [DATA_W-1:0]  wrData,
  input logic               done,
  input logic               busy,
  input logic               issueErr
);

  a_r3_onehot_req: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdReq));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq != '0) && ((rdReq & rdGrant) == '0)) |=> (rdReq == $past(rdReq)));

  a_r7_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrGrant) |=> (wrReq && $stable(wrData)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pipeGo) |-> $past(wrReq && wrGrant));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    issueErr |=> issueErr);

  a_r2_busy_covers: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq != '0) || wrReq || pipeGo || done) |-> busy);

endmodule

bind fu_opnd_ctrl fu_opnd_ctrl_chk #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdGrant(rdGrant), .pipeGo(pipeGo),
  .wrReq(wrReq), .wrGrant(wrGrant), .wrData(wrData), .done(done),
  .busy(busy), .issueErr(issueErr)
);

// File: tb/sim_fu_opnd_ctrl.sv
`timescale 1ns/1ps
module sim_fu_opnd_ctrl;

  localparam int NUM_OPS = 2;
  localparam int DATA_W  = 32;
  localparam int OPC_W   = 4;

  logic clk = 1'b0;
  logic rstN;
  logic issueValid, issueHasResult;
  logic [OPC_W-1:0] issueOpcode;
  logic [NUM_OPS-1:0] rdReq, rdGrant;
  logic [DATA_W-1:0] rdData, pipeResult, wrData;
  logic pipeGo, pipeResultValid, wrReq, wrGrant, done, busy, issueErr;
  logic [OPC_W-1:0] pipeOpcode;
  logic [NUM_OPS*DATA_W-1:0] pipeOperands;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  fu_opnd_ctrl #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W), .OPC_W(OPC_W)) u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOpcode(issueOpcode),
    .issueHasResult(issueHasResult), .rdReq(rdReq), .rdGrant(rdGrant),
    .rdData(rdData), .pipeGo(pipeGo), .pipeOpcode(pipeOpcode),
    .pipeOperands(pipeOperands), .pipeResultValid(pipeResultValid),
    .pipeResult(pipeResult), .wrReq(wrReq), .wrData(wrData), .wrGrant(wrGrant),
    .done(done), .busy(busy), .issueErr(issueErr)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; issueValid = 0; issueOpcode = '0; issueHasResult = 0;
    rdGrant = '0; rdData = '0; pipeResultValid = 0; pipeResult = '0; wrGrant = 0;
    repeat (3) step();
    chk({busy, done, pipeGo, wrReq, issueErr} == 5'b0, "R1 ctrl outs in reset",
        {busy, done, pipeGo, wrReq, issueErr}, 0);
    chk(rdReq == '0, "R1 rdReq in reset", rdReq, 0);
    rstN = 1'b1;
    step();
    chk(!busy && rdReq == '0, "R1 idle after reset", {busy, rdReq}, 0);
  endtask

  task automatic t_result_op();
    issueValid = 1; issueOpcode = 4'h5; issueHasResult = 1;
    step();
    issueValid = 0;
    chk(busy, "R2 busy after issue", busy, 1);
    chk(rdReq == 2'b01, "R2 first request operand 0", rdReq, 2'b01);
    rdGrant = 2'b10; rdData = 32'hDEAD0000;
    step();
    chk(rdReq == 2'b01, "R3 wrong-index grant ignored", rdReq, 2'b01);
    rdGrant = 2'b01; rdData = 32'h1111AAAA;
    step();
    rdGrant = '0; rdData = 32'hBAD0BAD0;
    chk(rdReq == 2'b10, "R3 advance to operand 1", rdReq, 2'b10);
    repeat (4) step();
    chk(rdReq == 2'b10 && !pipeGo, "R11 read held without grant", rdReq, 2'b10);
    rdGrant = 2'b10; rdData = 32'h2222BBBB;
    step();
    rdGrant = '0;
    chk(pipeGo, "R5 launch after last grant", pipeGo, 1);
    chk(pipeOpcode == 4'h5, "R5 opcode at launch", pipeOpcode, 4'h5);
    chk(pipeOperands[0 +: DATA_W] == 32'h1111AAAA, "R4 operand 0 latch",
        pipeOperands[0 +: DATA_W], 32'h1111AAAA);
    chk(pipeOperands[DATA_W +: DATA_W] == 32'h2222BBBB, "R4 operand 1 latch",
        pipeOperands[DATA_W +: DATA_W], 32'h2222BBBB);
    chk(!done && rdReq == '0, "R6 no done at launch", {done, rdReq}, 0);
    step();
    chk(!pipeGo, "R5 launch is one cycle", pipeGo, 0);
    repeat (3) begin
      chk(!done && !wrReq, "R6 waiting on result", {done, wrReq}, 0);
      step();
    end
    pipeResultValid = 1; pipeResult = 32'hC0FFEE01;
    step();
    pipeResultValid = 0; pipeResult = 32'h0BADF00D;
    chk(wrReq && wrData == 32'hC0FFEE01, "R7 write request with result",
        wrData, 32'hC0FFEE01);
    repeat (3) step();
    chk(wrReq && !done, "R11 write held without grant", {wrReq, done}, 2'b10);
    chk(wrData == 32'hC0FFEE01, "R7 output latch stable", wrData, 32'hC0FFEE01);
    wrGrant = 1;
    step();
    wrGrant = 0;
    chk(done && !wrReq, "R8 done after write grant", {done, wrReq}, 2'b10);
    step();
    chk(!done && !busy, "R8 done pulse then idle", {done, busy}, 0);
  endtask

  task automatic t_store_op();
    issueValid = 1; issueOpcode = 4'hA; issueHasResult = 0;
    step();
    issueValid = 0;
    rdGrant = 2'b01; rdData = 32'h5;
    step();
    rdGrant = 2'b10; rdData = 32'h6;
    step();
    rdGrant = '0;
    chk(pipeGo && done, "R9 done with launch", {pipeGo, done}, 2'b11);
    chk(!wrReq, "R9 no write request", wrReq, 0);
    chk(pipeOperands == {32'h6, 32'h5}, "R4 store operands", pipeOperands,
        {32'h6, 32'h5});
    step();
    chk(!busy && !done && !wrReq, "R9 idle after store", {busy, done, wrReq}, 0);
  endtask

  task automatic t_busy_issue();
    chk(!issueErr, "R10 no error before", issueErr, 0);
    issueValid = 1; issueOpcode = 4'h3; issueHasResult = 0;
    step();
    issueOpcode = 4'h9; issueHasResult = 1;
    step();
    issueValid = 0;
    chk(issueErr, "R10 error flag set", issueErr, 1);
    chk(rdReq == 2'b01, "R10 in-flight op unchanged", rdReq, 2'b01);
    rdGrant = 2'b01; step();
    rdGrant = 2'b10; step();
    rdGrant = '0;
    chk(pipeOpcode == 4'h3 && done, "R10 original opcode kept", pipeOpcode, 4'h3);
    step();
    chk(issueErr && !busy, "R10 error is sticky", {issueErr, busy}, 2'b10);
  endtask

  initial begin
    step();
    t_reset();
    t_result_op();
    t_store_op();
    t_busy_issue();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule